// File: doc/BRIEF.md
# Prescaled 32-bit Timer Channel

This block is a single 32-bit up-counting timer channel. Its count advances on a stream of input clock enables that first pass through a prescaler, which can divide them by 1, 8, 16 or 256. Software sets the channel up through a small register port. It can write the mode word, the count and the compare target. It can read the live count, the mode word with its status flags, and the target. A read has no side effects.

The channel watches for two events. The first is the count reaching an armed compare target. The second is the count wrapping past its all-ones value. Either event can set a sticky status flag and raise a one-cycle interrupt pulse, and the interrupt controller outside the block picks that pulse up. On a target hit the channel can restart from the excess over the target, and it can keep the target armed for repeated hits. A target written at or below the current count stays inactive until the count has wrapped once. The low three mode bits would select a gate on other channels. This channel has no gate input, so two of those codes simply hold the counter stopped.

Top module: `tmr32_prescaled_chan`

## Requirements
- R1: After reset the count reads 0, the target reads 0, the mode word reads 0x0400, and the interrupt output is low.
- R2: Mode bits 14:13 choose how many input enables make one count step: 00 gives 1, 01 gives 8, 10 gives 16, 11 gives 256. Idle cycles between enables do not disturb the division.
- R3: When mode bits 2:0 equal 3'b001 or 3'b111 the count and prescaler hold regardless of input enables. Every other value of those bits lets the channel count.
- R4: A mode write sets the count to 0 and restarts the prescaler phase. It also sets mode bit 10 to 1, clears status bits 11 and 12, and arms the target.
- R5: A step taken at count 0xFFFFFFFF wraps the count to 0 and re-arms the target. If overflow interrupt enable (bit 5) is set, it also sets overflow flag bit 12 and pulses the interrupt.
- R6: A step that brings the count to or above an armed target is a target hit, except on a wrapping step. If target interrupt enable (bit 4) is set, a hit sets target flag bit 11 and pulses the interrupt.
- R7: On a hit with bit 3 set, the count becomes the stepped value minus the target, and the target stays armed only if bit 6 is set. On a hit with bit 3 clear, the count keeps climbing and the target is disarmed.
- R8: When bit 7 is set, any event that pulses the interrupt clears mode bit 10. When bit 7 is clear, bit 10 stays 1.
- R9: A target written at or below the current count is disarmed until the next wrap.
- R10: A count write loads the value and arms the target while the prescaler phase keeps running, so the distance to the next step is kept.
- R11: Register select 0 addresses the count, 1 the mode word (bits 15:0) and 2 the target. Select 3 reads 0 and ignores writes. A read changes nothing.
- R12: The interrupt output is a single-cycle pulse, high only in the cycle after a step that produced an enabled event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Input clock enable fed to the prescaler |
| bus_wr_i | input | 1 | Write strobe for the register selected by bus_sel_i |
| bus_sel_i | input | 2 | Register select for reads and writes (0 count, 1 mode, 2 target, 3 none) |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for the selected register, combinational |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest state to reach is a target written behind the count that must stay silent across a wrap and then fire. Coming up from zero would take four billion steps. The bench instead loads the count a few steps below all-ones, writes a small target, and steps through the wrap, checking that no pulse appears until the count climbs back to the target. Prescaler phase retention is checked by loading the count partway through a divide-by-8 period and timing the next step. The division ratios are swept over all four settings and several enable counts around each period boundary, with and without idle cycles between enables.

// File: rtl/tmr32_pkg.sv
package tmr32_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_MODE   = 2'd1,
        SEL_TARGET = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int MODE_W = 16;

    typedef struct packed {
        logic [1:0] div_sel;
        logic       ovf_flag;
        logic       tgt_flag;
        logic       irq_n;
        logic       toggle;
        logic       rpt_en;
        logic       ovf_ie;
        logic       tgt_ie;
        logic       clr_on_tgt;
        logic [2:0] gate_cfg;
    } mode_t;

    localparam mode_t MODE_RST = '{div_sel: 2'b00, ovf_flag: 1'b0, tgt_flag: 1'b0,
                                   irq_n: 1'b1, toggle: 1'b0, rpt_en: 1'b0,
                                   ovf_ie: 1'b0, tgt_ie: 1'b0, clr_on_tgt: 1'b0,
                                   gate_cfg: 3'b000};

    function automatic mode_t word_to_mode(input logic [MODE_W-1:0] w);
        mode_t m;
        m.gate_cfg   = w[2:0];
        m.clr_on_tgt = w[3];
        m.tgt_ie     = w[4];
        m.ovf_ie     = w[5];
        m.rpt_en     = w[6];
        m.toggle     = w[7];
        m.irq_n      = 1'b1;
        m.tgt_flag   = 1'b0;
        m.ovf_flag   = 1'b0;
        m.div_sel    = w[14:13];
        return m;
    endfunction

    function automatic logic [MODE_W-1:0] mode_to_word(input mode_t m);
        logic [MODE_W-1:0] w;
        w        = '0;
        w[2:0]   = m.gate_cfg;
        w[3]     = m.clr_on_tgt;
        w[4]     = m.tgt_ie;
        w[5]     = m.ovf_ie;
        w[6]     = m.rpt_en;
        w[7]     = m.toggle;
        w[10]    = m.irq_n;
        w[11]    = m.tgt_flag;
        w[12]    = m.ovf_flag;
        w[14:13] = m.div_sel;
        return w;
    endfunction

endpackage

// File: rtl/tmr32_prescaler.sv
module tmr32_prescaler #(
    parameter int DIV_SH1 = 3,
    parameter int DIV_SH2 = 4,
    parameter int DIV_SH3 = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       run_i,
    input  logic       restart_i,
    input  logic [1:0] div_sel_i,
    output logic       step_o
);
    localparam int PRE_W = DIV_SH3;
    localparam logic [PRE_W-1:0] LIM1 = PRE_W'((1 << DIV_SH1) - 1);
    localparam logic [PRE_W-1:0] LIM2 = PRE_W'((1 << DIV_SH2) - 1);
    localparam logic [PRE_W-1:0] LIM3 = PRE_W'((1 << DIV_SH3) - 1);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        st_d   = st_q;
        step_o = 1'b0;
        case (div_sel_i)
            2'd0:    lim = '0;
            2'd1:    lim = LIM1;
            2'd2:    lim = LIM2;
            default: lim = LIM3;
        endcase
        if (restart_i) begin
            st_d.phase = '0;
        end else if (run_i && tick_i) begin
            if (st_q.phase >= lim) begin
                st_d.phase = '0;
                step_o     = 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R2
    phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.phase <= lim);

    // R3
    phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !restart_i) |=> st_q.phase == $past(st_q.phase));

endmodule

// File: rtl/tmr32_count_core.sv
module tmr32_count_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             mode_wr_i,
    input  logic             cnt_wr_i,
    input  logic             tgt_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             clr_on_tgt_i,
    input  logic             rpt_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] tgt_o,
    output logic             tgt_evt_o,
    output logic             ovf_evt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] tgt;
        logic             armed;
    } core_st_t;

    core_st_t         st_d, st_q;
    logic [CNT_W-1:0] nxt;
    logic             at_max;

    always_comb begin
        st_d      = st_q;
        tgt_evt_o = 1'b0;
        ovf_evt_o = 1'b0;
        nxt       = st_q.cnt + 1'b1;
        at_max    = &st_q.cnt;
        if (step_i) begin
            if (at_max) begin
                st_d.cnt   = '0;
                st_d.armed = 1'b1;
                ovf_evt_o  = 1'b1;
            end else if (st_q.armed && (nxt >= st_q.tgt)) begin
                tgt_evt_o = 1'b1;
                if (clr_on_tgt_i) begin
                    st_d.cnt   = nxt - st_q.tgt;
                    st_d.armed = rpt_en_i;
                end else begin
                    st_d.cnt   = nxt;
                    st_d.armed = 1'b0;
                end
            end else begin
                st_d.cnt = nxt;
            end
        end
        if (mode_wr_i) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else if (cnt_wr_i) begin
            st_d.cnt   = wdata_i;
            st_d.armed = 1'b1;
        end else if (tgt_wr_i) begin
            st_d.tgt   = wdata_i;
            st_d.armed = (wdata_i > st_d.cnt);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign tgt_o = st_q.tgt;

    // R5
    wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && (&st_q.cnt) && !mode_wr_i && !cnt_wr_i && !tgt_wr_i)
        |=> (st_q.cnt == '0) && st_q.armed);

    // R4
    mode_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_wr_i |=> (st_q.cnt == '0) && st_q.armed);

    // R9
    late_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tgt_wr_i && !step_i && !mode_wr_i && !cnt_wr_i && (wdata_i <= st_q.cnt))
        |=> !st_q.armed);

endmodule

// File: rtl/tmr32_mode_reg.sv
module tmr32_mode_reg
    import tmr32_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [MODE_W-1:0] wdata_i,
    input  logic              tgt_evt_i,
    input  logic              ovf_evt_i,
    output mode_t             mode_o,
    output logic              irq_o
);
    typedef struct packed {
        mode_t mode;
        logic  irq;
    } mreg_st_t;

    mreg_st_t st_d, st_q;
    logic     hit_tgt, hit_ovf;

    always_comb begin
        st_d     = st_q;
        hit_tgt  = tgt_evt_i && st_q.mode.tgt_ie;
        hit_ovf  = ovf_evt_i && st_q.mode.ovf_ie;
        st_d.irq = 1'b0;
        if (wr_i) begin
            st_d.mode = word_to_mode(wdata_i);
        end else begin
            if (hit_tgt) st_d.mode.tgt_flag = 1'b1;
            if (hit_ovf) st_d.mode.ovf_flag = 1'b1;
            if ((hit_tgt || hit_ovf) && st_q.mode.toggle) st_d.mode.irq_n = 1'b0;
            st_d.irq = hit_tgt || hit_ovf;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mode <= MODE_RST;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign irq_o  = st_q.irq;

    // R4
    mode_wr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> st_q.mode.irq_n && !st_q.mode.tgt_flag && !st_q.mode.ovf_flag);

    // R12
    irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.irq |-> (st_q.mode.tgt_flag || st_q.mode.ovf_flag));

    // R12
    irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tgt_evt_i && !ovf_evt_i) |=> !st_q.irq);

endmodule

// File: rtl/tmr32_prescaled_chan.sv
module tmr32_prescaled_chan
    import tmr32_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int DIV_SH1 = 3,
    parameter int DIV_SH2 = 4,
    parameter int DIV_SH3 = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_en_i,
    input  logic             bus_wr_i,
    input  logic [1:0]       bus_sel_i,
    input  logic [CNT_W-1:0] bus_wdata_i,
    output logic [CNT_W-1:0] bus_rdata_o,
    output logic             irq_o
);
    reg_sel_e         sel;
    logic             mode_wr, cnt_wr, tgt_wr;
    logic             stopped, step;
    logic             tgt_evt, ovf_evt;
    mode_t            mode;
    logic [CNT_W-1:0] cnt, tgt;

    assign sel     = reg_sel_e'(bus_sel_i);
    assign mode_wr = bus_wr_i && (sel == SEL_MODE);
    assign cnt_wr  = bus_wr_i && (sel == SEL_COUNT);
    assign tgt_wr  = bus_wr_i && (sel == SEL_TARGET);
    assign stopped = (mode.gate_cfg == 3'b001) || (mode.gate_cfg == 3'b111);

    tmr32_prescaler #(
        .DIV_SH1 (DIV_SH1),
        .DIV_SH2 (DIV_SH2),
        .DIV_SH3 (DIV_SH3)
    ) pre_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_en_i),
        .run_i     (!stopped),
        .restart_i (mode_wr),
        .div_sel_i (mode.div_sel),
        .step_o    (step)
    );

    tmr32_count_core #(
        .CNT_W (CNT_W)
    ) core_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .step_i       (step),
        .mode_wr_i    (mode_wr),
        .cnt_wr_i     (cnt_wr),
        .tgt_wr_i     (tgt_wr),
        .wdata_i      (bus_wdata_i),
        .clr_on_tgt_i (mode.clr_on_tgt),
        .rpt_en_i     (mode.rpt_en),
        .cnt_o        (cnt),
        .tgt_o        (tgt),
        .tgt_evt_o    (tgt_evt),
        .ovf_evt_o    (ovf_evt)
    );

    tmr32_mode_reg mreg_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (mode_wr),
        .wdata_i   (bus_wdata_i[MODE_W-1:0]),
        .tgt_evt_i (tgt_evt),
        .ovf_evt_i (ovf_evt),
        .mode_o    (mode),
        .irq_o     (irq_o)
    );

    always_comb begin
        case (sel)
            SEL_COUNT:  bus_rdata_o = cnt;
            SEL_MODE:   bus_rdata_o = CNT_W'(mode_to_word(mode));
            SEL_TARGET: bus_rdata_o = tgt;
            default:    bus_rdata_o = '0;
        endcase
    end

    // R3
    stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stopped && !bus_wr_i) |=> $stable(cnt));

    // R2
    no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_en_i && !bus_wr_i) |=> $stable(cnt));

endmodule

// File: tb/tmr32_prescaled_chan_tb.sv
`timescale 1ns/1ps
module tmr32_prescaled_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    int irq_cnt = 0;
    logic last_irq = 1'b0;
    logic [31:0] v;

    always #2.5 clk = ~clk;

    tmr32_prescaled_chan dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_en_i   (tick_en),
        .bus_wr_i    (bus_wr),
        .bus_sel_i   (bus_sel),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle; inputs change 1 ns after an edge, irq sampled 1 ns after the next edge
    task automatic cyc(input logic en);
        tick_en = en;
        @(posedge clk);
        #1;
        last_irq = irq;
        if (irq) irq_cnt++;
        tick_en = 1'b0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1);
            for (int g = 0; g < gap; g++) cyc(1'b0);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        bus_sel   = sel;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        bus_sel = sel;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 irq in reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        cyc(1'b0);
        rd(2'd0, v); chk("R1 count", v, 32'h0);
        rd(2'd1, v); chk("R1 mode", v, 32'h0400);
        rd(2'd2, v); chk("R1 target", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 sweep over ratios, enable counts and enable spacing
        for (int s = 0; s < 4; s++) begin
            for (int gap = 0; gap < 2; gap++) begin
                for (int j = 0; j < 4; j++) begin
                    int n, k;
                    n = (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 16 : 256;
                    k = (j == 0) ? n - 1 : (j == 1) ? n : (j == 2) ? 3 * n - 1 : 3 * n;
                    wr(2'd1, 32'(s) << 13);
                    ticks(k, gap);
                    rd(2'd0, v);
                    chk($sformatf("R2 ratio %0d ticks %0d", n, k), v, 32'(k / n));
                end
            end
        end

        // R10 count write keeps prescaler phase
        wr(2'd1, 32'h2000);
        ticks(5, 0);
        wr(2'd0, 32'd100);
        rd(2'd2, v);
        ticks(2, 0);
        rd(2'd0, v); chk("R10 before step", v, 32'd100);
        ticks(1, 0);
        rd(2'd0, v); chk("R10 phase kept", v, 32'd101);

        // R4 mode write restarts the phase
        wr(2'd1, 32'h2000);
        ticks(5, 0);
        wr(2'd1, 32'h2000);
        ticks(7, 0);
        rd(2'd0, v); chk("R4 phase restarted", v, 32'd0);
        ticks(1, 0);
        rd(2'd0, v); chk("R4 first step", v, 32'd1);

        // R3 stop codes
        wr(2'd1, 32'h1); ticks(20, 0); rd(2'd0, v); chk("R3 code 1 stops", v, 32'd0);
        wr(2'd1, 32'h7); ticks(20, 0); rd(2'd0, v); chk("R3 code 7 stops", v, 32'd0);
        wr(2'd1, 32'h3); ticks(20, 0); rd(2'd0, v); chk("R3 code 3 runs", v, 32'd20);
        wr(2'd1, 32'h5); ticks(20, 0); rd(2'd0, v); chk("R3 code 5 runs", v, 32'd20);

        // R5 overflow with interrupt
        wr(2'd1, 32'h20);
        wr(2'd0, 32'hFFFF_FFFE);
        cyc(1'b1); chk("R12 no irq before wrap", {31'b0, last_irq}, 32'h0);
        cyc(1'b1); chk("R5 irq on wrap", {31'b0, last_irq}, 32'h1);
        rd(2'd0, v); chk("R5 wrapped count", v, 32'h0);
        cyc(1'b0); chk("R12 pulse one cycle", {31'b0, last_irq}, 32'h0);
        rd(2'd1, v); chk("R5 overflow flag", v, 32'h1420);

        // R6 R7 reset on target with repeat
        wr(2'd1, 32'h58);
        wr(2'd2, 32'd10);
        irq_cnt = 0;
        ticks(9, 0);
        chk("R6 no early hit", 32'(irq_cnt), 32'd0);
        ticks(1, 0);
        chk("R6 irq on hit", {31'b0, last_irq}, 32'h1);
        rd(2'd0, v); chk("R7 count cleared on hit", v, 32'd0);
        rd(2'd1, v); chk("R6 target flag", v, 32'h0C58);
        irq_cnt = 0;
        ticks(10, 0);
        chk("R7 repeat hit", 32'(irq_cnt), 32'd1);
        rd(2'd0, v); chk("R7 repeat count", v, 32'd0);

        // R7 reset on target without repeat
        wr(2'd1, 32'h18);
        wr(2'd2, 32'd5);
        irq_cnt = 0;
        ticks(5, 0);
        chk("R7 single hit", 32'(irq_cnt), 32'd1);
        irq_cnt = 0;
        ticks(5, 0);
        chk("R7 disarmed after hit", 32'(irq_cnt), 32'd0);
        rd(2'd0, v); chk("R7 keeps counting", v, 32'd5);

        // R7 no reset on target
        wr(2'd1, 32'h10);
        wr(2'd2, 32'd5);
        irq_cnt = 0;
        ticks(5, 0);
        rd(2'd0, v); chk("R7 no clear at hit", v, 32'd5);
        ticks(3, 0);
        chk("R7 one hit only", 32'(irq_cnt), 32'd1);
        rd(2'd0, v); chk("R7 climbs past target", v, 32'd8);
        rd(2'd1, v); chk("R8 bit10 kept without toggle", v, 32'h0C10);

        // R9 target at current count
        wr(2'd1, 32'h10);
        wr(2'd0, 32'd20);
        wr(2'd2, 32'd20);
        irq_cnt = 0;
        ticks(5, 0);
        chk("R9 equal target inactive", 32'(irq_cnt), 32'd0);
        rd(2'd0, v); chk("R9 count", v, 32'd25);

        // R9 target behind count armed after wrap
        wr(2'd0, 32'hFFFF_FFF0);
        wr(2'd2, 32'd5);
        irq_cnt = 0;
        ticks(16, 0);
        rd(2'd0, v); chk("R9 wrapped", v, 32'd0);
        chk("R9 silent before wrap", 32'(irq_cnt), 32'd0);
        ticks(4, 0);
        chk("R9 not yet", 32'(irq_cnt), 32'd0);
        ticks(1, 0);
        chk("R9 hit after wrap", {31'b0, last_irq}, 32'h1);

        // R8 toggle clears bit 10, R4 mode write restores it
        wr(2'd1, 32'h90);
        wr(2'd2, 32'd3);
        ticks(3, 0);
        rd(2'd1, v); chk("R8 bit10 cleared", v, 32'h0890);
        wr(2'd1, 32'h90);
        rd(2'd1, v); chk("R4 flags reset", v, 32'h0490);
        rd(2'd0, v); chk("R4 count zero", v, 32'd0);

        // R11 reads and reserved select
        wr(2'd1, 32'h0);
        wr(2'd0, 32'd77);
        wr(2'd2, 32'd1234);
        wr(2'd3, 32'hDEAD_BEEF);
        rd(2'd3, v); chk("R11 reserved reads zero", v, 32'h0);
        rd(2'd2, v); chk("R11 target read", v, 32'd1234);
        rd(2'd0, v); chk("R11 count read", v, 32'd77);
        rd(2'd0, v); chk("R11 read repeat", v, 32'd77);
        rd(2'd1, v); chk("R11 mode read", v, 32'h0400);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule